// File: doc/BRIEF.md
# Capture-Compare Timer with Sticky Overflow

The block is an up-counter that advances only on cycles where a count enable is high. It has two registers beside the counter: a compare register that software loads, and a capture register that takes the counter value on a valid edge of an external trigger pin. The counter has three modes. It can run freely and wrap. It can return to zero after the count that equals the compare register. It can return to zero on a valid trigger edge. A sticky overflow flag records every wrap from the all-ones count to zero. This includes the case where clear-on-match mode returns to zero because the compare register holds all ones.

Software reaches the block through two strobes. A write strobe either loads the compare register or clears the overflow flag. A read strobe returns one of the two registers one cycle later, together with a valid bit. The valid bit drops when a capture updates the capture register in the same cycle as a read of it. In that cycle the capture takes effect and the returned word is not guaranteed. After a wrap, the flag cannot be cleared until the counter has taken its next count step.

The trigger pin passes through a synchronizer of `SYNC_STAGES` flops and then an edge detector. An input selects whether rising or falling edges are valid. The match and capture interrupts are single-cycle pulses.

Top module: `ccTimer`

## Requirements
- R1: After reset the counter, compare register, capture register and overflow flag read zero, and `matchIrq`, `capIrq` and `rdValid` are low.
- R2: The counter changes only on clock edges where `countEn` is high, or on a valid trigger edge in trigger-clear mode. While `countEn` is low it holds its value.
- R3: `modeSel` selects the mode: 2'b00 free-running, 2'b01 clear on compare match, 2'b10 clear on trigger edge, and 2'b11 behaves as free-running. In free-running mode, a count step taken while the counter equals the compare register pulses `matchIrq` and the counter still increments. A step from all ones to zero sets `ovfFlag`.
- R4: In clear-on-match mode (2'b01), a count step taken while the counter equals the compare register returns the counter to zero and pulses `matchIrq` for one cycle.
- R5: In clear-on-match mode with the compare register at all ones, the step at the all-ones count pulses `matchIrq`, returns the counter to zero and sets `ovfFlag`.
- R6: In trigger-clear mode (2'b10), a valid trigger edge returns the counter to zero in place of any step, whatever `countEn` is. The same edge captures the pre-clear count.
- R7: A valid trigger edge latches the counter into the capture register and pulses `capIrq` for one cycle. `edgeSel`=1 selects rising edges and `edgeSel`=0 selects falling edges, and an edge of the other polarity has no effect.
- R8: A flag clear issued after a wrap but before the next count step is ignored, so the flag stays set. A clear issued after that step succeeds.
- R9: `ovfFlag` stays set until a successful clear. When a wrap and a clear coincide, the wrap wins.
- R10: A read strobe `rdEn` with `rdSel`=0 returns the compare register, and with `rdSel`=1 returns the capture register. `rdData` and `rdValid`=1 appear on the next cycle.
- R11: If a capture occurs in the same cycle as a read of the capture register, the capture register still takes the new count and `rdValid` is low on the following cycle.
- R12: A write strobe `wrEn` with `wrSel`=0 loads `wrData` into the compare register. With `wrSel`=1 it requests a flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countEn | input | 1 | Count step enable |
| modeSel | input | 2 | Counting mode |
| edgeSel | input | 1 | Valid trigger polarity: 1 rising, 0 falling |
| capPin | input | 1 | Asynchronous trigger pin |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | Write target: 0 compare load, 1 flag clear |
| wrData | input | WIDTH | Compare value to load |
| rdEn | input | 1 | Read strobe |
| rdSel | input | 1 | Read target: 0 compare, 1 capture |
| rdData | output | WIDTH | Read data, one cycle after the strobe |
| rdValid | output | 1 | Read data is guaranteed |
| count | output | WIDTH | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| matchIrq | output | 1 | Compare match pulse |
| capIrq | output | 1 | Capture pulse |

## Verification
The bench builds the block with `WIDTH`=8 and `SYNC_STAGES`=2. The narrow counter makes each wrap take 256 steps, so the run can reach the all-ones count several times. That covers the free-running wrap, the compare-at-all-ones roll in clear-on-match mode, and the window in which a flag clear is refused. With two synchronizer stages, the capture happens on a known cycle, three edges after the pin changes. The bench uses that to place a read on exactly the capture cycle and to check the count a running counter held when the trigger edge cleared it.

// File: rtl/ccTimerPkg.sv
package ccTimerPkg;

  typedef enum logic [1:0] {
    MODE_FREE      = 2'b00,
    MODE_CLR_MATCH = 2'b01,
    MODE_CLR_EDGE  = 2'b10,
    MODE_RSVD      = 2'b11
  } timerMode_e;

  // Strobes from control to datapath, all valid for the current cycle
  typedef struct packed {
    logic cntInc;    // step the counter by one
    logic cntClr;    // return the counter to zero
    logic ovfSet;    // wrap happened
    logic ovfClr;    // accepted flag clear
    logic capLoad;   // latch the counter into the capture register
    logic matchHit;  // counter equals compare on a step
    logic cmpLoad;   // load the compare register
    logic rdLoad;    // register a read
    logic rdPick;    // 0 compare, 1 capture
    logic rdOk;      // read data is guaranteed
  } ctrlStrobes_s;

endpackage

// File: rtl/ccTimerCtrl.sv
module ccTimerCtrl
  import ccTimerPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               countEn,
  input  logic [1:0]         modeSel,
  input  logic               edgeSel,
  input  logic               capPin,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic               rdEn,
  input  logic               rdSel,
  input  logic [WIDTH-1:0]   cntVal,
  input  logic [WIDTH-1:0]   cmpVal,
  output ctrlStrobes_s       strobes
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  // Synchronizer chain for the trigger pin
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= capPin;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  logic pinLvl;
  logic riseEvt;
  logic fallEvt;
  logic edgeEvt;

  assign pinLvl  = syncQ[SYNC_STAGES-1];
  assign riseEvt = pinLvl & ~prevQ;
  assign fallEvt = ~pinLvl & prevQ;
  assign edgeEvt = edgeSel ? riseEvt : fallEvt;

  // Mode decode and counter decisions
  timerMode_e mode;
  logic       atMax;
  logic       isMatch;
  logic       edgeClr;
  logic       matchClr;
  logic       wrapEvt;
  logic       guardQ;

  assign mode     = timerMode_e'(modeSel);
  assign atMax    = (cntVal == CNT_MAX);
  assign isMatch  = (cntVal == cmpVal);
  assign edgeClr  = (mode == MODE_CLR_EDGE) && edgeEvt;
  assign matchClr = countEn && (mode == MODE_CLR_MATCH) && isMatch;
  assign wrapEvt  = countEn && atMax && !edgeClr;

  // Guard: set on a wrap, released by the next count step or trigger clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   guardQ <= 1'b0;
    else if (wrapEvt)            guardQ <= 1'b1;
    else if (countEn || edgeClr) guardQ <= 1'b0;
  end

  always_comb begin
    strobes          = '0;
    strobes.cntClr   = edgeClr || matchClr;
    strobes.cntInc   = countEn && !(edgeClr || matchClr);
    strobes.ovfSet   = wrapEvt;
    strobes.ovfClr   = wrEn && wrSel && !guardQ && !wrapEvt;
    strobes.capLoad  = edgeEvt;
    strobes.matchHit = countEn && isMatch;
    strobes.cmpLoad  = wrEn && !wrSel;
    strobes.rdLoad   = rdEn;
    strobes.rdPick   = rdSel;
    strobes.rdOk     = rdEn && !(rdSel && edgeEvt);
  end

endmodule

// File: rtl/ccTimerDatapath.sv
module ccTimerDatapath
  import ccTimerPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_s       strobes,
  input  logic [WIDTH-1:0]   wrData,
  output logic [WIDTH-1:0]   cntVal,
  output logic [WIDTH-1:0]   cmpVal,
  output logic [WIDTH-1:0]   rdData,
  output logic               rdValid,
  output logic               ovfFlag,
  output logic               matchIrq,
  output logic               capIrq
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] cmpQ;
  logic [WIDTH-1:0] capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobes.cntClr) cntQ <= '0;
    else if (strobes.cntInc) cntQ <= cntQ + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cmpQ <= '0;
    else if (strobes.cmpLoad) cmpQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                capQ <= '0;
    else if (strobes.capLoad) capQ <= cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ovfFlag <= 1'b0;
    else if (strobes.ovfSet) ovfFlag <= 1'b1;
    else if (strobes.ovfClr) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchIrq <= 1'b0;
      capIrq   <= 1'b0;
    end else begin
      matchIrq <= strobes.matchHit;
      capIrq   <= strobes.capLoad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdOk;
      if (strobes.rdLoad) rdData <= strobes.rdPick ? capQ : cmpQ;
    end
  end

  assign cntVal = cntQ;
  assign cmpVal = cmpQ;

endmodule

// File: rtl/ccTimer.sv
module ccTimer
  import ccTimerPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic [1:0]       modeSel,
  input  logic             edgeSel,
  input  logic             capPin,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic             rdSel,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag,
  output logic             matchIrq,
  output logic             capIrq
);

  ctrlStrobes_s     strobes;
  logic [WIDTH-1:0] cntVal;
  logic [WIDTH-1:0] cmpVal;

  ccTimerCtrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .countEn (countEn),
    .modeSel (modeSel),
    .edgeSel (edgeSel),
    .capPin  (capPin),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .rdEn    (rdEn),
    .rdSel   (rdSel),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .strobes (strobes)
  );

  ccTimerDatapath #(.WIDTH(WIDTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .cntVal   (cntVal),
    .cmpVal   (cmpVal),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .ovfFlag  (ovfFlag),
    .matchIrq (matchIrq),
    .capIrq   (capIrq)
  );

  assign count = cntVal;

endmodule

// File: rtl/ccTimerChk.sv
module ccTimerChk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             countEn,
  input logic [1:0]       modeSel,
  input logic             wrEn,
  input logic             wrSel,
  input logic             rdEn,
  input logic             rdValid,
  input logic [WIDTH-1:0] count,
  input logic             ovfFlag,
  input logic             capIrq
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && modeSel != 2'b10) |=> $stable(count)); // R2

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && modeSel == 2'b00 && count != CNT_MAX) |=> (count == $past(count) + WIDTH'(1))); // R3

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && count == CNT_MAX && modeSel != 2'b10) |=> ovfFlag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrEn && wrSel)) |=> ovfFlag); // R9

  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |=> !capIrq); // R7

  AST_READ_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn)); // R10

endmodule

bind ccTimer ccTimerChk #(.WIDTH(WIDTH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .countEn (countEn),
  .modeSel (modeSel),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .rdEn    (rdEn),
  .rdValid (rdValid),
  .count   (count),
  .ovfFlag (ovfFlag),
  .capIrq  (capIrq)
);

// File: tb/ccTimer_bench.sv
`timescale 1ns/1ps
module ccTimer_bench;

  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         countEn = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         edgeSel = 1'b1;
  logic         capPin = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic         rdSel = 1'b0;
  logic [W-1:0] rdData;
  logic         rdValid;
  logic [W-1:0] count;
  logic         ovfFlag;
  logic         matchIrq;
  logic         capIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ccTimer #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_ccTimer (
    .clk(clk), .rstN(rstN), .countEn(countEn), .modeSel(modeSel),
    .edgeSel(edgeSel), .capPin(capPin), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData),
    .rdValid(rdValid), .count(count), .ovfFlag(ovfFlag),
    .matchIrq(matchIrq), .capIrq(capIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    countEn = 1'b1;
    repeat (n) @(negedge clk);
    countEn = 1'b0;
  endtask

  task automatic writeCmp(input int v);
    wrEn = 1'b1; wrSel = 1'b0; wrData = W'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearFlag();
    wrEn = 1'b1; wrSel = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0;
  endtask

  task automatic readReg(input bit sel, output int data, output int valid);
    rdEn = 1'b1; rdSel = sel;
    @(negedge clk);
    rdEn = 1'b0;
    data = int'(rdData);
    valid = int'(rdValid);
  endtask

  task automatic testReset();
    int d, v;
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk("R1 count", count, 0);
    chk("R1 ovfFlag", ovfFlag, 0);
    chk("R1 matchIrq", matchIrq, 0);
    chk("R1 capIrq", capIrq, 0);
    chk("R1 rdValid", rdValid, 0);
    readReg(1'b0, d, v);
    chk("R1 compare reg", d, 0);
    readReg(1'b1, d, v);
    chk("R1 capture reg", d, 0);
  endtask

  task automatic testEnable();
    idle(5);
    chk("R2 hold with enable low", count, 0);
    runTicks(10);
    chk("R2 ten steps", count, 10);
    idle(4);
    runTicks(5);
    chk("R2 steps resume", count, 15);
  endtask

  task automatic testWriteRead();
    int d, v;
    writeCmp(8'h14);
    readReg(1'b0, d, v);
    chk("R12 compare load", d, 8'h14);
    chk("R10 read valid", v, 1);
  endtask

  task automatic testFreeRun();
    modeSel = 2'b00;
    runTicks(5);
    chk("R3 reached compare", count, 8'h14);
    runTicks(1);
    chk("R3 match does not clear", count, 8'h15);
    chk("R3 match pulse", matchIrq, 1);
    idle(1);
    chk("R3 match pulse ends", matchIrq, 0);
    runTicks(255 - 8'h15);
    chk("R3 at max", count, 255);
    chk("R3 no flag yet", ovfFlag, 0);
    runTicks(1);
    chk("R3 wrapped count", count, 0);
    chk("R3 wrap sets flag", ovfFlag, 1);
    // clear before the next step must be refused
    clearFlag();
    chk("R8 clear refused in window", ovfFlag, 1);
    idle(6);
    chk("R9 flag sticky", ovfFlag, 1);
    runTicks(1);
    clearFlag();
    chk("R8 clear after step", ovfFlag, 0);
  endtask

  task automatic testClrMatch();
    int d, v;
    modeSel = 2'b01;
    writeCmp(5);
    runTicks(4);
    chk("R4 reached compare", count, 5);
    runTicks(1);
    chk("R4 match clears", count, 0);
    chk("R4 match pulse", matchIrq, 1);
    idle(1);
    chk("R4 pulse single", matchIrq, 0);
    runTicks(6);
    chk("R4 second period", count, 0);
    writeCmp(8'hFF);
    runTicks(255);
    chk("R5 at max", count, 255);
    chk("R5 flag clear before roll", ovfFlag, 0);
    runTicks(1);
    chk("R5 rolled to zero", count, 0);
    chk("R5 match pulse at max", matchIrq, 1);
    chk("R5 flag set", ovfFlag, 1);
    readReg(1'b0, d, v);
    chk("R10 compare readback", d, 8'hFF);
    runTicks(1);
    clearFlag();
    chk("R12 flag clear", ovfFlag, 0);
  endtask

  task automatic testCapture();
    int d, v, x, y, z, pulses;
    modeSel = 2'b00;
    edgeSel = 1'b1;
    runTicks(3);
    x = int'(count);
    capPin = 1'b1;
    idle(SYNC + 1);
    chk("R7 rising capture pulse", capIrq, 1);
    idle(1);
    chk("R7 capture pulse single", capIrq, 0);
    readReg(1'b1, d, v);
    chk("R7 rising capture value", d, x);
    runTicks(7);
    y = int'(count);
    capPin = 1'b0;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (capIrq) pulses++;
    end
    chk("R7 falling ignored pulse", pulses, 0);
    readReg(1'b1, d, v);
    chk("R7 falling ignored value", d, x);
    chk("R7 count moved", (y != x) ? 1 : 0, 1);
    edgeSel = 1'b0;
    capPin = 1'b1;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (capIrq) pulses++;
    end
    chk("R7 rising ignored when falling selected", pulses, 0);
    runTicks(2);
    z = int'(count);
    capPin = 1'b0;
    idle(SYNC + 1);
    chk("R7 falling capture pulse", capIrq, 1);
    readReg(1'b1, d, v);
    chk("R7 falling capture value", d, z);
  endtask

  task automatic testEdgeClear();
    int d, v, c;
    edgeSel = 1'b1;
    modeSel = 2'b10;
    runTicks(4);
    idle(2);
    c = int'(count);
    capPin = 1'b1;
    countEn = 1'b1;
    idle(SYNC + 1);
    chk("R6 edge clears running counter", count, 0);
    chk("R6 capture pulse", capIrq, 1);
    idle(1);
    countEn = 1'b0;
    chk("R6 counting resumes", count, 1);
    readReg(1'b1, d, v);
    chk("R6 pre-clear count captured", d, (c + SYNC) & 8'hFF);
    capPin = 1'b0;
    idle(4);
    chk("R6 falling edge no clear", count, 1);
  endtask

  task automatic testCollision();
    int d, v, w;
    modeSel = 2'b00;
    edgeSel = 1'b1;
    runTicks(9);
    w = int'(count);
    capPin = 1'b1;
    idle(SYNC);
    rdEn = 1'b1; rdSel = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R11 read flagged invalid", rdValid, 0);
    chk("R11 capture still taken", capIrq, 1);
    readReg(1'b1, d, v);
    chk("R11 capture register updated", d, w);
    chk("R11 later read valid", v, 1);
    capPin = 1'b0;
    idle(4);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testEnable();
    testWriteRead();
    testFreeRun();
    testClrMatch();
    testCapture();
    testEdgeClear();
    testCollision();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule